// File: doc/BRIEF.md
# Issue Queue Wakeup and Select

This block is the scheduling core of an out-of-order issue window. Each entry holds one waiting instruction, described by the physical tags of its two source operands (left and right), a ready flag for each source, and the physical tag of its destination. Every cycle a set of result tags is presented on a broadcast bus. Each entry compares every tag on the bus against both of its source tags, and any match marks that source ready.

An entry whose two sources are both ready requests issue. A tree of four-input fixed-priority arbiter cells collects the requests. Request activity travels up the tree as an any-request flag, and an enable travels back down to become a one-hot grant. One selector is built per functional unit. Each later selector sees only the requests that the earlier selectors left ungranted, so every unit receives a distinct entry in the same cycle.

A granted entry leaves the window at the end of its issue cycle. Its destination tag is placed on the internal half of the broadcast bus in the following cycle. Wakeup feeds the request logic within that same cycle, so a dependent instruction can issue in the cycle right after its producer. The external half of the bus carries tags from longer-latency producers. Operand values, the register file and bypass paths sit outside this block.

Top module: `iq_wakeup_select`

## Requirements
- R1: After reset, no entry is valid. `issue_valid` and `bcast_valid` are all zero and `full` is low.
- R2: An accepted allocation fills the lowest-numbered invalid entry. `full` is high exactly when every entry is valid. An allocation presented while `full` is high is dropped, and the window's contents do not change.
- R3: A source becomes ready in any of these cases: its ready flag is set at allocation, or its tag matches a valid tag on the broadcast bus (internal or external) in the allocation cycle or in any later cycle. Once a source is ready it stays ready while the entry is valid.
- R4: An entry requests issue only when it is valid and both of its sources are ready, where readiness includes matches on the current cycle's bus. An entry with one source still waiting is not issued.
- R5: Unit 0 is granted the lowest-numbered requesting entry. Unit 1 is granted the lowest-numbered requesting entry other than that one. Each grant is one-hot, and the two units never receive the same entry.
- R6: A granted entry is invalidated at the end of its issue cycle and is never issued twice.
- R7: A destination tag issued on unit f in cycle T appears on `bcast_valid[f]` and on slice f of `bcast_tag` in cycle T+1. An entry waiting only on that tag issues in cycle T+1.
- R8: When more entries request than there are units, the rest keep requesting and issue in later cycles, still in ascending index order.
- R9: For unit f, slice f of `issue_idx` gives the granted entry number in binary (unit f occupies bits f*IDX_W upward), and slice f of `issue_dst` carries the destination tag stored in that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocation request this cycle |
| alloc_src_l | input | TAG_W | Left source tag |
| alloc_rdy_l | input | 1 | Left source already ready |
| alloc_src_r | input | TAG_W | Right source tag |
| alloc_rdy_r | input | 1 | Right source already ready |
| alloc_dst | input | TAG_W | Destination tag |
| full | output | 1 | All entries valid; allocation is dropped |
| ext_wake_valid | input | EXT_N | Valid flags for the external wake tags |
| ext_wake_tag | input | EXT_N*TAG_W | External wake tags |
| issue_valid | output | NUM_FU | Grant present, one bit per unit |
| issue_idx | output | NUM_FU*IDX_W | Granted entry number for each unit |
| issue_dst | output | NUM_FU*TAG_W | Destination tag of each granted entry |
| bcast_valid | output | NUM_FU | Internal broadcast valid (previous cycle's issues) |
| bcast_tag | output | NUM_FU*TAG_W | Internal broadcast tags |

## Verification
The bench uses the defaults: 16 entries, 7-bit tags, two units and one external wake port. With these values the tree has exactly two full levels, with no padding. Filling all sixteen entries exercises the full flag and the dropped allocation. One external tag then wakes all sixteen entries at once, and the window drains two per cycle over eight cycles in strict index order. The single external port lets the bench release dependences one tag at a time. This makes the same-cycle allocation wakeup visible, as well as the case of an entry held back by its second source.

// File: rtl/iq_wakeup_select.sv
module iq_wakeup_select #(
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 7,
  parameter int NUM_FU  = 2,
  parameter int EXT_N   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  input  logic [TAG_W-1:0]          alloc_src_l,
  input  logic                      alloc_rdy_l,
  input  logic [TAG_W-1:0]          alloc_src_r,
  input  logic                      alloc_rdy_r,
  input  logic [TAG_W-1:0]          alloc_dst,
  output logic                      full,
  input  logic [EXT_N-1:0]          ext_wake_valid,
  input  logic [EXT_N*TAG_W-1:0]    ext_wake_tag,
  output logic [NUM_FU-1:0]         issue_valid,
  output logic [NUM_FU*$clog2(ENTRIES)-1:0] issue_idx,
  output logic [NUM_FU*TAG_W-1:0]   issue_dst,
  output logic [NUM_FU-1:0]         bcast_valid,
  output logic [NUM_FU*TAG_W-1:0]   bcast_tag
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int LV    = (IDX_W + 1) / 2;
  localparam int PAD   = 1 << (2 * LV);
  localparam int NB    = NUM_FU + EXT_N;

  logic [ENTRIES-1:0] ent_v, rdy_l, rdy_r;
  logic [TAG_W-1:0]   tag_l [ENTRIES];
  logic [TAG_W-1:0]   tag_r [ENTRIES];
  logic [TAG_W-1:0]   dst   [ENTRIES];

  logic [NB-1:0]       bus_v;
  logic [NB*TAG_W-1:0] bus_t;
  assign bus_v = {ext_wake_valid, bcast_valid};
  assign bus_t = {ext_wake_tag, bcast_tag};

  function automatic logic hit(input logic [TAG_W-1:0] t);
    logic m;
    m = 1'b0;
    for (int b = 0; b < NB; b++)
      m = m | (bus_v[b] && bus_t[b*TAG_W +: TAG_W] == t);
    return m;
  endfunction

  logic [ENTRIES-1:0] now_l, now_r, req;
  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      now_l[e] = rdy_l[e] | hit(tag_l[e]);
      now_r[e] = rdy_r[e] | hit(tag_r[e]);
      req[e]   = ent_v[e] & now_l[e] & now_r[e];
    end
  end

  logic [IDX_W-1:0] free_idx;
  logic             alloc_we;
  always_comb begin
    free_idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--)
      if (!ent_v[e]) free_idx = IDX_W'(e);
  end
  assign full     = &ent_v;
  assign alloc_we = alloc_valid & ~full;

  logic [NUM_FU*ENTRIES-1:0] gnt_flat;
  logic [ENTRIES-1:0]        taken;

  for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
    logic [PAD-1:0]   reqp, gnt;
    logic [IDX_W-1:0] idx;

    if (f == 0) begin : g_first
      assign reqp = PAD'(req);
    end else begin : g_next
      assign reqp = g_fu[f-1].reqp & ~g_fu[f-1].gnt;
    end

    for (genvar l = 0; l < LV; l++) begin : g_up
      localparam int CELLS = PAD >> (2 * (l + 1));
      logic [4*CELLS-1:0] din;
      logic [CELLS-1:0]   any;
      if (l == 0) begin : g_leaf
        assign din = reqp;
      end else begin : g_inner
        assign din = g_up[l-1].any;
      end
      always_comb
        for (int c = 0; c < CELLS; c++) any[c] = |din[4*c +: 4];
    end

    for (genvar k = 0; k < LV; k++) begin : g_dn
      localparam int L     = LV - 1 - k;
      localparam int CELLS = PAD >> (2 * (L + 1));
      logic [CELLS-1:0]   en;
      logic [4*CELLS-1:0] go;
      if (k == 0) begin : g_root
        assign en = 1'b1;
      end else begin : g_sub
        assign en = g_dn[k-1].go;
      end
      always_comb begin
        logic seen;
        for (int c = 0; c < CELLS; c++) begin
          seen = 1'b0;
          for (int i = 0; i < 4; i++) begin
            go[4*c+i] = en[c] & g_up[L].din[4*c+i] & ~seen;
            seen      = seen | g_up[L].din[4*c+i];
          end
        end
      end
    end

    assign gnt = g_dn[LV-1].go;

    always_comb begin
      idx = '0;
      for (int e = 0; e < ENTRIES; e++)
        if (gnt[e]) idx = IDX_W'(e);
    end

    assign issue_valid[f]                = g_up[LV-1].any[0];
    assign issue_idx[f*IDX_W +: IDX_W]   = idx;
    assign issue_dst[f*TAG_W +: TAG_W]   = dst[idx];
    assign gnt_flat[f*ENTRIES +: ENTRIES] = gnt[ENTRIES-1:0];

    assert_onehot_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
    assert_grant_needs_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[ENTRIES-1:0] & ~req) == '0);
    assert_granted_leaves_R6: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid[f] |=> !ent_v[$past(idx)]);
    assert_bcast_next_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid[f] |=> bcast_valid[f] &&
        bcast_tag[f*TAG_W +: TAG_W] == $past(issue_dst[f*TAG_W +: TAG_W]));
  end

  always_comb begin
    taken = '0;
    for (int f = 0; f < NUM_FU; f++) taken = taken | gnt_flat[f*ENTRIES +: ENTRIES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v       <= '0;
      rdy_l       <= '0;
      rdy_r       <= '0;
      bcast_valid <= '0;
      bcast_tag   <= '0;
    end else begin
      rdy_l       <= now_l;
      rdy_r       <= now_r;
      ent_v       <= ent_v & ~taken;
      bcast_valid <= issue_valid;
      bcast_tag   <= issue_dst;
      if (alloc_we) begin
        ent_v[free_idx] <= 1'b1;
        rdy_l[free_idx] <= alloc_rdy_l | hit(alloc_src_l);
        rdy_r[free_idx] <= alloc_rdy_r | hit(alloc_src_r);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_we) begin
      tag_l[free_idx] <= alloc_src_l;
      tag_r[free_idx] <= alloc_src_r;
      dst[free_idx]   <= alloc_dst;
    end
  end

  assert_lowest_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req & (g_fu[0].gnt[ENTRIES-1:0] - ENTRIES'(1))) == '0);
  assert_full_drops_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_valid) |=> $countones(ent_v) <= $past($countones(ent_v)));
  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_v & $past(ent_v) & $past(rdy_l) & ~rdy_l) == '0);
endmodule

// File: tb/test_iq_wakeup_select.sv
module test_iq_wakeup_select;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_valid = 1'b0;
  logic [6:0] alloc_src_l = '0, alloc_src_r = '0, alloc_dst = '0;
  logic       alloc_rdy_l = 1'b0, alloc_rdy_r = 1'b0;
  logic       full;
  logic [0:0] ext_wake_valid = '0;
  logic [6:0] ext_wake_tag = '0;
  logic [1:0] issue_valid, bcast_valid;
  logic [7:0] issue_idx;
  logic [13:0] issue_dst, bcast_tag;

  iq_wakeup_select i_iq_wakeup_select (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_src_l(alloc_src_l), .alloc_rdy_l(alloc_rdy_l),
    .alloc_src_r(alloc_src_r), .alloc_rdy_r(alloc_rdy_r), .alloc_dst(alloc_dst),
    .full(full), .ext_wake_valid(ext_wake_valid), .ext_wake_tag(ext_wake_tag),
    .issue_valid(issue_valid), .issue_idx(issue_idx), .issue_dst(issue_dst),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag));

  always #2 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    q_cyc[$], q_fu[$], q_idx[$], q_dst[$];
  string q_req[$];
  int    ai, ad;

  task automatic expect_issue(int c, int f, int i, int d, string r);
    q_cyc.push_back(c); q_fu.push_back(f); q_idx.push_back(i);
    q_dst.push_back(d); q_req.push_back(r);
  endtask

  task automatic pop_front();
    void'(q_cyc.pop_front()); void'(q_fu.pop_front()); void'(q_idx.pop_front());
    void'(q_dst.pop_front()); void'(q_req.pop_front());
  endtask

  task automatic chk(bit ok, string r, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    alloc_valid = 1'b0; ext_wake_valid = '0;
  endtask

  task automatic alloc(int sl, bit rl, int sr, bit rr, int d);
    alloc_valid = 1'b1;
    alloc_src_l = 7'(sl); alloc_rdy_l = rl;
    alloc_src_r = 7'(sr); alloc_rdy_r = rr;
    alloc_dst = 7'(d);
  endtask

  task automatic wake(int t);
    ext_wake_valid = 1'b1; ext_wake_tag = 7'(t);
  endtask

  // Scoreboard monitor: compares each issue against the front of the queue
  always @(negedge clk) if (rst_n) begin
    while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
      checks++; errors++;
      $display("FAIL %s missing issue: actual=none expected idx=%0d dst=%0d cycle=%0d",
               q_req[0], q_idx[0], q_dst[0], q_cyc[0]);
      pop_front();
    end
    for (int f = 0; f < 2; f++) if (issue_valid[f]) begin
      checks++;
      ai = int'(issue_idx[f*4 +: 4]);
      ad = int'(issue_dst[f*7 +: 7]);
      if (q_cyc.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected issue: actual fu=%0d idx=%0d dst=%0d expected=none",
                 f, ai, ad);
      end else begin
        if (q_cyc[0] != cyc || q_fu[0] != f || q_idx[0] != ai || q_dst[0] != ad) begin
          errors++;
          $display("FAIL %s issue: actual cyc=%0d fu=%0d idx=%0d dst=%0d expected cyc=%0d fu=%0d idx=%0d dst=%0d",
                   q_req[0], cyc, f, ai, ad, q_cyc[0], q_fu[0], q_idx[0], q_dst[0]);
        end
        pop_front();
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int k, m, w;
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk(issue_valid == 2'b00, "R1", "issue_valid", issue_valid, 0);
    chk(bcast_valid == 2'b00, "R1", "bcast_valid", bcast_valid, 0);
    chk(full == 1'b0, "R1", "full", full, 0);

    // Back-to-back dependent pair; R9 idx/dst, R7 wakeup from own broadcast
    step(); k = cyc;
    alloc(1, 1, 2, 1, 10);
    expect_issue(k + 1, 0, 0, 10, "R9");
    step();
    alloc(10, 0, 3, 1, 11);
    expect_issue(k + 2, 0, 1, 11, "R7");
    step();
    chk(bcast_valid == 2'b01, "R7", "bcast_valid", bcast_valid, 1);
    chk(bcast_tag[6:0] == 7'd10, "R7", "bcast_tag0", bcast_tag[6:0], 10);
    step(); step();

    // Five waiters on tag 50; last also needs 51 (R4, R5, R8, R3)
    for (int i = 0; i < 5; i++) begin
      step();
      alloc(50, 0, (i == 4) ? 51 : 5, (i == 4) ? 1'b0 : 1'b1, 20 + i);
      chk(issue_valid == 2'b00, "R4", "no issue while waiting", issue_valid, 0);
    end
    step(); m = cyc;
    wake(50);
    expect_issue(m, 0, 0, 20, "R5");
    expect_issue(m, 1, 1, 21, "R5");
    expect_issue(m + 1, 0, 2, 22, "R8");
    expect_issue(m + 1, 1, 3, 23, "R8");
    step();
    chk(bcast_valid == 2'b11, "R7", "bcast_valid pair", bcast_valid, 3);
    chk(bcast_tag[6:0] == 7'd20, "R7", "bcast_tag0", bcast_tag[6:0], 20);
    chk(bcast_tag[13:7] == 7'd21, "R7", "bcast_tag1", bcast_tag[13:7], 21);
    step();
    chk(issue_valid == 2'b00, "R4", "one source pending", issue_valid, 0);
    step();
    wake(51);
    expect_issue(m + 3, 0, 4, 24, "R3");
    step(); step();

    // R3: wake tag presented in the allocation cycle itself
    step();
    alloc(60, 0, 61, 0, 40);
    wake(60);
    step(); step();
    wake(61);
    expect_issue(cyc, 0, 0, 40, "R3");
    step(); step();

    // R2: fill all entries, drop an extra allocation, then drain (R8)
    for (int i = 0; i < 16; i++) begin
      step();
      alloc(70, 0, 5, 1, 30 + i);
    end
    step();
    chk(full == 1'b1, "R2", "full after 16", full, 1);
    alloc(1, 1, 2, 1, 99);
    step();
    chk(full == 1'b1, "R2", "full after dropped alloc", full, 1);
    step(); w = cyc;
    wake(70);
    for (int j = 0; j < 8; j++) begin
      expect_issue(w + j, 0, 2 * j, 30 + 2 * j, "R8");
      expect_issue(w + j, 1, 2 * j + 1, 31 + 2 * j, "R8");
    end
    repeat (9) step();
    chk(full == 1'b0, "R2", "full after drain", full, 0);
    repeat (3) step();
    chk(q_cyc.size() == 0, "R6", "pending expected issues", q_cyc.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule